// File: doc/BRIEF.md
# Colored-Button Unlock Code Detector

This block is a synchronous Moore state machine that drives a door-lock release. The lock opens only when a start button is pressed and then a fixed code of colored buttons follows. The button panel gives one line per color (red, green, blue) and one summary flag that is high whenever any colored button is down. The machine counts how far the code has been entered. It waits in place while no colored button is down. It goes back to idle on any press that is not exactly the expected color by itself.

Because the check for the expected color also requires the other color lines to be low, a press of several colors at once counts as an error. Holding every button down therefore cannot open the lock. The code is a parameter. It defaults to red, blue, green, red. The unlock output is a pure decode of the state register. It stays high for exactly one clock and the machine then returns to idle.

Top module: `code_lock_detector`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) puts the machine in idle at once, with `unlock_o` low, whatever state it was in.
- R2: In idle the machine stays idle while `start_i` is low, whatever the color lines and `any_i` do.
- R3: In idle, `start_i` high at a clock edge moves the machine to the armed state, which expects the first code color.
- R4: In the armed state and in every partly-entered state, a clock edge with `any_i` low keeps the state, whatever the color lines show.
- R5: In those states, a clock edge with `any_i` high and only the expected color line high advances one step. `CODE_SEQ` holds `CODE_LEN` two-bit color codes, element 0 in the lowest bits and entered first. The codes are 0 red, 1 green and 2 blue. The default code is red, blue, green, red.
- R6: In those states, a clock edge with `any_i` high and anything other than the lone expected color sends the machine to idle. This covers a wrong color, two or three colors together, and no color line at all.
- R7: `unlock_o` is high only in the final state, which is reached after the last code color. It lasts exactly one cycle, and the machine then returns to idle whatever the inputs are.
- R8: `start_i` has no effect outside idle.
- R9: A press held over more than one clock edge is taken as a new press at each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start button |
| red_i | input | 1 | Red button line |
| green_i | input | 1 | Green button line |
| blue_i | input | 1 | Blue button line |
| any_i | input | 1 | High when some colored button is down |
| unlock_o | output | 1 | Door release, high in the final state only |

## Verification
The bench builds the block with its defaults: a four-color code of red, blue, green, red, which gives six reachable states and two unused state codes. This lets one color (red) appear twice in the code. It also brings a wrong press, a multi-color press and a lone summary flag within reach at every step of the code. A reference model in the bench predicts the state. Random presses are biased toward the expected color so that full unlocks happen. Directed runs cover gaps with the color lines but no flag, start held throughout, a held press, and a reset in the middle of the code.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;

  // Color codes used inside the code sequence parameter
  localparam int NUM_COLORS = 3;
  localparam logic [1:0] COL_RED   = 2'd0;
  localparam logic [1:0] COL_GREEN = 2'd1;
  localparam logic [1:0] COL_BLUE  = 2'd2;

  // Default code: red, blue, green, red (element 0 in the low bits)
  localparam int         DEFAULT_LEN = 4;
  localparam logic [7:0] DEFAULT_SEQ = {COL_RED, COL_GREEN, COL_BLUE, COL_RED};

  // Classification of the button panel against the expected color
  typedef enum logic [1:0] {
    PRESS_NONE = 2'd0,
    PRESS_HIT  = 2'd1,
    PRESS_MISS = 2'd2
  } press_t;

endpackage

// File: rtl/code_lock_step_rom.sv
// Maps the current state index to the one-hot color line pattern that it expects.
module code_lock_step_rom #(
  parameter int CODE_LEN = 4,
  parameter logic [2*CODE_LEN-1:0] CODE_SEQ = 8'h18,
  parameter int SW = 3
) (
  input  logic [SW-1:0]                         state_q,
  output logic [code_lock_pkg::NUM_COLORS-1:0]  expected_oh
);
  localparam int NC = code_lock_pkg::NUM_COLORS;

  logic [NC-1:0] step_oh [CODE_LEN];

  // One entry per code element, each a one-hot color line pattern
  for (genvar k = 0; k < CODE_LEN; k++) begin : g_step
    assign step_oh[k] = NC'(1) << CODE_SEQ[2*k +: 2];
  end

  // State k+1 expects element k; other states get an all-zero pattern
  always_comb begin
    expected_oh = '0;
    for (int k = 0; k < CODE_LEN; k++) begin
      if (state_q == SW'(k + 1)) begin
        expected_oh = step_oh[k];
      end
    end
  end

endmodule

// File: rtl/code_lock_press_classify.sv
// Decides whether the panel shows nothing, exactly the expected color, or anything else.
module code_lock_press_classify (
  input  logic [code_lock_pkg::NUM_COLORS-1:0] colors,
  input  logic [code_lock_pkg::NUM_COLORS-1:0] expected_oh,
  input  logic                                 any_press,
  output code_lock_pkg::press_t                press_kind
);
  import code_lock_pkg::*;

  logic exact;

  // The expected color must be the only line high: extra colors are a miss
  assign exact = (colors == expected_oh) && (expected_oh != '0);

  always_comb begin
    if (!any_press) begin
      press_kind = PRESS_NONE;
    end else if (exact) begin
      press_kind = PRESS_HIT;
    end else begin
      press_kind = PRESS_MISS;
    end
  end

endmodule

// File: rtl/code_lock_next_state.sv
// Transition logic: per state, the conditions are mutually exclusive and cover every input.
module code_lock_next_state #(
  parameter int CODE_LEN = 4,
  parameter int SW = 3
) (
  input  logic [SW-1:0]          state_q,
  input  logic                   start,
  input  code_lock_pkg::press_t  press_kind,
  output logic [SW-1:0]          state_d
);
  import code_lock_pkg::*;

  localparam int           NUM_STATES = CODE_LEN + 2;
  localparam logic [SW-1:0] IDLE_ST   = '0;
  localparam logic [SW-1:0] ARMED_ST  = SW'(1);
  localparam logic [SW-1:0] FINAL_ST  = SW'(CODE_LEN + 1);

  logic legal;

  // Unused state codes exist only when the state count is not a power of two
  if (NUM_STATES < (1 << SW)) begin : g_recover
    assign legal = (state_q <= FINAL_ST);
  end else begin : g_full
    assign legal = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    if (!legal) begin
      state_d = IDLE_ST;
    end else if (state_q == IDLE_ST) begin
      if (start) begin
        state_d = ARMED_ST;
      end
    end else if (state_q == FINAL_ST) begin
      state_d = IDLE_ST;
    end else begin
      unique case (press_kind)
        PRESS_NONE: state_d = state_q;
        PRESS_HIT:  state_d = state_q + 1'b1;
        default:    state_d = IDLE_ST;
      endcase
    end
  end

endmodule

// File: rtl/code_lock_state_reg.sv
// State flops with asynchronous active-low reset and an explicit update enable.
module code_lock_state_reg #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] state_d,
  output logic [SW-1:0] state_q
);
  logic upd_en;

  assign upd_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/code_lock_detector.sv
// Top: colored-button unlock code detector (Moore machine).
module code_lock_detector #(
  parameter int CODE_LEN = code_lock_pkg::DEFAULT_LEN,
  parameter logic [2*CODE_LEN-1:0] CODE_SEQ = code_lock_pkg::DEFAULT_SEQ
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic red_i,
  input  logic green_i,
  input  logic blue_i,
  input  logic any_i,
  output logic unlock_o
);
  import code_lock_pkg::*;

  localparam int            NUM_STATES = CODE_LEN + 2;
  localparam int            SW         = $clog2(NUM_STATES);
  localparam logic [SW-1:0] FINAL_ST   = SW'(CODE_LEN + 1);

  logic [SW-1:0]         state_q;
  logic [SW-1:0]         state_d;
  logic [NUM_COLORS-1:0] colors;
  logic [NUM_COLORS-1:0] expected_oh;
  press_t                press_kind;

  // Bit order follows the color codes: bit 0 red, bit 1 green, bit 2 blue
  assign colors = {blue_i, green_i, red_i};

  code_lock_step_rom #(
    .CODE_LEN (CODE_LEN),
    .CODE_SEQ (CODE_SEQ),
    .SW       (SW)
  ) i_rom (
    .state_q     (state_q),
    .expected_oh (expected_oh)
  );

  code_lock_press_classify i_cls (
    .colors      (colors),
    .expected_oh (expected_oh),
    .any_press   (any_i),
    .press_kind  (press_kind)
  );

  code_lock_next_state #(
    .CODE_LEN (CODE_LEN),
    .SW       (SW)
  ) i_nxt (
    .state_q    (state_q),
    .start      (start_i),
    .press_kind (press_kind),
    .state_d    (state_d)
  );

  code_lock_state_reg #(
    .SW (SW)
  ) i_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .state_q (state_q)
  );

  // Moore output: a decode of the state register alone
  assign unlock_o = (state_q == FINAL_ST);

endmodule

// File: rtl/code_lock_detector_chk.sv
// Property checker, bound to every instance of the top module.
module code_lock_detector_chk #(
  parameter int CODE_LEN = 4,
  parameter logic [2*CODE_LEN-1:0] CODE_SEQ = 8'h18,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          red_i,
  input logic          green_i,
  input logic          blue_i,
  input logic          any_i,
  input logic          unlock_o,
  input logic [SW-1:0] state_q
);
  localparam logic [SW-1:0] FINAL_ST = SW'(CODE_LEN + 1);

  logic       in_prog;
  logic       lone_expected;
  logic [1:0] want;

  assign in_prog = (state_q != '0) && (state_q != FINAL_ST) && (state_q < FINAL_ST);

  // Color code wanted in the current state, taken straight from the parameter
  always_comb begin
    want = 2'd3;
    for (int k = 0; k < CODE_LEN; k++) begin
      if (state_q == SW'(k + 1)) want = CODE_SEQ[2*k +: 2];
    end
  end

  always_comb begin
    unique case (want)
      2'd0:    lone_expected = red_i && !green_i && !blue_i;
      2'd1:    lone_expected = green_i && !red_i && !blue_i;
      2'd2:    lone_expected = blue_i && !red_i && !green_i;
      default: lone_expected = 1'b0;
    endcase
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0 && !start_i) |=> (state_q == '0));

  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0 && start_i) |=> (state_q == SW'(1)));

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && !any_i) |=> $stable(state_q));

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && any_i && lone_expected) |=> (state_q == $past(state_q) + 1'b1));

  p_wrong_press_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && any_i && !lone_expected) |=> (state_q == '0));

  p_multi_color_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && any_i && $countones({red_i, green_i, blue_i}) > 1) |=> !unlock_o);

  p_unlock_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_o |=> (!unlock_o && state_q == '0));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && !any_i && start_i) |=> $stable(state_q));

endmodule

bind code_lock_detector code_lock_detector_chk #(
  .CODE_LEN (CODE_LEN),
  .CODE_SEQ (CODE_SEQ),
  .SW       (SW)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .red_i    (red_i),
  .green_i  (green_i),
  .blue_i   (blue_i),
  .any_i    (any_i),
  .unlock_o (unlock_o),
  .state_q  (state_q)
);

// File: tb/test_code_lock_detector.sv
`timescale 1ns/1ps
module test_code_lock_detector;

  localparam int RED = 0, GREEN = 1, BLUE = 2;
  localparam int LEN = 4;
  localparam int FIN = LEN + 1;
  localparam int SEQ [LEN] = '{RED, BLUE, GREEN, RED};

  logic clk = 1'b0;
  logic rst_n, start_i, red_i, green_i, blue_i, any_i;
  logic unlock_o;

  int total = 0;
  int bad = 0;
  int mstate = 0;

  always #10 clk = ~clk;

  code_lock_detector i_code_lock_detector (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .red_i (red_i),
    .green_i (green_i), .blue_i (blue_i), .any_i (any_i), .unlock_o (unlock_o)
  );

  // Reference model built from the requirements
  function automatic int model_next(int s, bit st, bit r, bit g, bit b, bit a);
    int c;
    bit exact;
    if (s == 0) return st ? 1 : 0;        // R2, R3
    if (s == FIN) return 0;               // R7
    if (!a) return s;                     // R4, R8
    c = SEQ[s-1];
    exact = (r == (c == RED)) && (g == (c == GREEN)) && (b == (c == BLUE));
    return exact ? s + 1 : 0;             // R5, R6
  endfunction

  task automatic check(logic act, logic exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: unlock_o=%0b expected %0b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at a falling edge, check at the next falling edge
  task automatic step(bit st, bit r, bit g, bit b, bit a, string tag);
    int nxt;
    nxt = model_next(mstate, st, r, g, b, a);
    start_i = st; red_i = r; green_i = g; blue_i = b; any_i = a;
    @(posedge clk);
    @(negedge clk);
    mstate = nxt;
    check(unlock_o, logic'(mstate == FIN), tag);
  endtask

  task automatic press(int c, bit st, string tag);
    step(st, c == RED, c == GREEN, c == BLUE, 1'b1, tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic full_code(string tag);
    press(RED, 0, tag); press(BLUE, 0, tag); press(GREEN, 0, tag); press(RED, 0, tag);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Watchdog: counts as a failed check
  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    rst_n = 1'b0; start_i = 0; red_i = 0; green_i = 0; blue_i = 0; any_i = 0;
    repeat (2) @(negedge clk);
    check(unlock_o, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    mstate = 0;

    // R2: colors while idle without start do nothing
    press(RED, 0, "R2 idle ignores red");
    step(0, 1, 1, 1, 1, "R2 idle ignores all");

    // R3, R5, R7: correct code unlocks for one cycle
    step(1, 0, 0, 0, 0, "R3 start arms");
    full_code("R5 correct code");
    check(unlock_o, 1'b1, "R7 unlock after code");
    step(0, 1, 0, 0, 1, "R7 one-cycle pulse");
    check(unlock_o, 1'b0, "R7 back to idle");

    // R4: gaps with color lines up but no flag
    step(1, 0, 0, 0, 0, "R3 start");
    step(0, 1, 1, 1, 0, "R4 lines without flag");
    press(RED, 0, "R5 red");
    idle("R4 gap");
    step(0, 0, 0, 1, 0, "R4 blue line no flag");
    press(BLUE, 0, "R5 blue");
    idle("R4 gap");
    press(GREEN, 0, "R5 green");
    idle("R4 gap");
    press(RED, 0, "R5 red final");
    check(unlock_o, 1'b1, "R4 unlock with gaps");

    // R6: wrong order, then remaining code must not unlock
    idle("R7 leave final");
    step(1, 0, 0, 0, 0, "R3 start");
    press(BLUE, 0, "R6 wrong first color");
    full_code("R6 code without start");
    check(unlock_o, 1'b0, "R6 wrong order no unlock");

    // R6: simultaneous presses
    step(1, 0, 0, 0, 0, "R3 start");
    step(0, 1, 0, 1, 1, "R6 red+blue together");
    press(BLUE, 0, "R6 after multi"); press(GREEN, 0, "R6 after multi"); press(RED, 0, "R6 after multi");
    check(unlock_o, 1'b0, "R6 multi press no unlock");
    step(1, 0, 0, 0, 0, "R3 start");
    press(RED, 0, "R5 red");
    step(0, 1, 1, 1, 1, "R6 all colors");
    press(GREEN, 0, "R6 after all"); press(RED, 0, "R6 after all");
    check(unlock_o, 1'b0, "R6 all-colors no unlock");

    // R6: flag alone, and interrupted code
    step(1, 0, 0, 0, 0, "R3 start");
    step(0, 0, 0, 0, 1, "R6 flag with no color");
    step(1, 0, 0, 0, 0, "R3 start");
    press(RED, 0, "R5 red"); press(BLUE, 0, "R5 blue");
    press(RED, 0, "R6 interrupted");
    press(GREEN, 0, "R6 after interrupt"); press(RED, 0, "R6 after interrupt");
    check(unlock_o, 1'b0, "R6 interrupted no unlock");

    // R8: start held through the whole code
    step(1, 0, 0, 0, 0, "R3 start");
    press(RED, 1, "R8 start held"); press(BLUE, 1, "R8 start held");
    step(1, 0, 0, 0, 0, "R8 start during gap");
    press(GREEN, 1, "R8 start held"); press(RED, 1, "R8 start held");
    check(unlock_o, 1'b1, "R8 start ignored mid-code");
    idle("R7 leave final");

    // R9: held red counts twice and breaks the code
    step(1, 0, 0, 0, 0, "R3 start");
    press(RED, 0, "R9 red first edge");
    press(RED, 0, "R9 red held second edge");
    press(BLUE, 0, "R9 after hold"); press(GREEN, 0, "R9 after hold"); press(RED, 0, "R9 after hold");
    check(unlock_o, 1'b0, "R9 held press no unlock");

    // R1: asynchronous reset mid-code
    step(1, 0, 0, 0, 0, "R3 start");
    press(RED, 0, "R5 red"); press(BLUE, 0, "R5 blue"); press(GREEN, 0, "R5 green");
    rst_n = 1'b0;
    #1;
    check(unlock_o, 1'b0, "R1 async reset");
    mstate = 0;
    @(negedge clk);
    rst_n = 1'b1;
    press(RED, 0, "R1 code lost after reset");
    check(unlock_o, 1'b0, "R1 no unlock after reset");

    // Random presses biased toward the expected color
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      if (mstate == 0) begin
        step(sel < 40, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R2/R3 random idle");
      end else if (mstate >= 1 && mstate <= LEN && sel < 60) begin
        press(SEQ[mstate-1], 1'($urandom), "R5 random hit");
      end else if (sel < 75) begin
        step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, "R4 random hold");
      end else begin
        step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R6/R7 random");
      end
    end

    summary();
    $finish;
  end

endmodule